// File: doc/BRIEF.md
# Core Test Wrapper with Surround Chain

This block puts a small digital core inside a test wrapper so that the core can be scan-tested by itself, cut off from the logic around it. Each functional input and each functional output gets a boundary cell. These boundary cells and the core's own internal flip-flops form one serial path. That path runs from a single scan input to a single scan output.

The three top-level test controls are reset, scan enable and test mode. Each one passes through a filter clocked on the test clock before any logic uses it, so a short pulse on the raw pin has no effect. The core stand-in has two clock domains, and the chain crosses from one to the other. A latch at that crossing holds the crossing bit for half a cycle, which stops hold-time races between the two domains. The same scan enable and test mode reach every core in a chip, so any core can be tested on its own. This block handles one core.

The core stand-in is parameterised by a width W and has two register banks:
- Bank A is on clock A.
- Bank B is on clock B.

Top module: `core_test_wrapper`

## Requirements
- R1: An input boundary cell register loads the previous chain bit on a clock edge when filtered scan enable is 1, and otherwise loads its functional input.
- R2: When filtered test mode is 1, each core input is driven from its input boundary cell register. When filtered test mode is 0, each core input is driven straight from `func_in`.
- R3: An output boundary cell register loads its core output bit when filtered scan enable is 0, and shifts the chain when it is 1. `func_out` always equals the core output.
- R4: The chain is 4*W bits long. Chain position 0 is the first bit after `scan_in`. The chain order is:
  - input cells 0..W-1;
  - bank A bits 0..W-1;
  - bank B bits 0..W-1;
  - output cells 0..W-1.
  With scan enable held, a bit applied to `scan_in` before edge k appears on `scan_out` after edge k+4*W-1.
- R5: The crossing from bank A bit W-1 (clock A) into bank B bit 0 (clock B) goes through a latch that is transparent while clock A is low. With both clocks in phase, this adds no shift cycle.
- R6: Each filtered control takes a new raw value only after the raw input has differed from the filtered value on HOLD consecutive rising edges of clock A. A pulse shorter than that is ignored. The scan enable and test mode filters clear to 0 while filtered reset is 1.
- R7: While filtered reset is 1, every chain register clears to 0 on the next edge, so `func_out` and `scan_out` read 0.
- R8: In capture mode (filtered scan enable 0), with core input vector x:
  - bank A loads x XOR rotl(A), where rotl(A) bit i is A bit i-1 and rotl(A) bit 0 is A bit W-1;
  - bank B loads A XOR B;
  - `func_out` shows bank B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Clock for input cells, bank A, control filters, lockup latch |
| clk_b | input | 1 | Clock for bank B and output cells |
| rst_in | input | 1 | Raw synchronous active-high reset, filtered |
| scan_en_in | input | 1 | Raw scan enable, filtered |
| test_mode_in | input | 1 | Raw test-mode select, filtered |
| scan_in | input | 1 | Serial chain input |
| func_in | input | W | Functional inputs to the core |
| func_out | output | W | Functional outputs of the core |
| scan_out | output | 1 | Serial chain output |

## Verification
The bench builds the wrapper with W=4 and HOLD=2, which gives a 16-bit chain. At that size the capture-mode sweep covers all sixteen input vectors, and every continuity pattern passes through every chain position, including the latch crossing. It also covers the boundary edges on both sides. HOLD=2 makes a one-cycle pulse the longest glitch that must be rejected, so the bench applies one on each of the three controls. Every edge is checked against an arithmetic model of the chain, the core and the filters.

// File: rtl/cw_pkg.sv
package cw_pkg;

    // Variant selector for a boundary cell.
    typedef enum logic {
        CELL_INPUT  = 1'b0,
        CELL_OUTPUT = 1'b1
    } cell_kind_e;

    // Filtered test controls, as seen by the whole wrapper.
    typedef struct packed {
        logic rst;
        logic scan_en;
        logic test_mode;
    } test_ctl_t;

endpackage

// File: rtl/cw_deglitch.sv
module cw_deglitch #(
    parameter int HOLD = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;

    logic [CW-1:0] cnt_q;
    logic          out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= 1'b0;
            cnt_q <= '0;
        end else if (din == out_q) begin
            cnt_q <= '0;
        end else if (cnt_q == CW'(HOLD - 1)) begin
            out_q <= din;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign dout = out_q;

    // R6
    filter_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (out_q != $past(out_q)) |-> ($past(din) == out_q));

endmodule

// File: rtl/cw_bound_cell.sv
module cw_bound_cell
    import cw_pkg::*;
#(
    parameter cell_kind_e KIND = CELL_INPUT
) (
    input  logic clk,
    input  logic rst,
    input  logic se,
    input  logic tm,
    input  logic shift_in,
    input  logic func_val,
    output logic q,
    output logic drive
);
    always_ff @(posedge clk) begin
        if (rst)     q <= 1'b0;
        else if (se) q <= shift_in;
        else         q <= func_val;
    end

    generate
        if (KIND == CELL_INPUT) begin : g_in
            assign drive = tm ? q : func_val;

            // R1
            in_capture_chk: assert property (@(posedge clk) disable iff (rst)
                !se |=> (q == $past(func_val)));
        end else begin : g_out
            assign drive = func_val;

            // R3
            out_capture_chk: assert property (@(posedge clk) disable iff (rst)
                (!se && tm) |=> (q == $past(func_val)));
        end
    endgenerate

    // R1
    cell_shift_chk: assert property (@(posedge clk) disable iff (rst)
        se |=> (q == $past(shift_in)));

endmodule

// File: rtl/cw_lockup.sv
module cw_lockup (
    input  logic clk,
    input  logic d,
    output logic q
);
    // Transparent while the launching clock is low.
    always_latch begin
        if (!clk) q <= d;
    end
endmodule

// File: rtl/cw_core.sv
module cw_core #(
    parameter int W = 4
) (
    input  logic         clk_a,
    input  logic         clk_b,
    input  logic         rst,
    input  logic         se,
    input  logic         scan_in,
    input  logic [W-1:0] core_in,
    output logic [W-1:0] core_out,
    output logic         scan_out
);
    logic [W-1:0] a_q;
    logic [W-1:0] b_q;
    logic         cross_q;
    logic [W-1:0] a_rot;

    assign a_rot = {a_q[W-2:0], a_q[W-1]};

    always_ff @(posedge clk_a) begin
        if (rst)     a_q <= '0;
        else if (se) a_q <= {a_q[W-2:0], scan_in};
        else         a_q <= core_in ^ a_rot;
    end

    cw_lockup u_lock (
        .clk (clk_a),
        .d   (a_q[W-1]),
        .q   (cross_q)
    );

    always_ff @(posedge clk_b) begin
        if (rst)     b_q <= '0;
        else if (se) b_q <= {b_q[W-2:0], cross_q};
        else         b_q <= a_q ^ b_q;
    end

    assign core_out = b_q;
    assign scan_out = b_q[W-1];

    // R5
    cross_shift_chk: assert property (@(posedge clk_b) disable iff (rst)
        se |=> (b_q[0] == $past(a_q[W-1])));

    // R8
    bank_b_capture_chk: assert property (@(posedge clk_b) disable iff (rst)
        !se |=> (b_q == ($past(a_q) ^ $past(b_q))));

endmodule

// File: rtl/core_test_wrapper.sv
module core_test_wrapper
    import cw_pkg::*;
#(
    parameter int W    = 4,
    parameter int HOLD = 2
) (
    input  logic         clk_a,
    input  logic         clk_b,
    input  logic         rst_in,
    input  logic         scan_en_in,
    input  logic         test_mode_in,
    input  logic         scan_in,
    input  logic [W-1:0] func_in,
    output logic [W-1:0] func_out,
    output logic         scan_out
);
    logic      rst_f, se_f, tm_f;
    test_ctl_t ctl;

    cw_deglitch #(.HOLD(HOLD)) u_flt_rst (
        .clk(clk_a), .rst(1'b0), .din(rst_in), .dout(rst_f));
    cw_deglitch #(.HOLD(HOLD)) u_flt_se (
        .clk(clk_a), .rst(rst_f), .din(scan_en_in), .dout(se_f));
    cw_deglitch #(.HOLD(HOLD)) u_flt_tm (
        .clk(clk_a), .rst(rst_f), .din(test_mode_in), .dout(tm_f));

    assign ctl = '{rst: rst_f, scan_en: se_f, test_mode: tm_f};

    logic [W:0]   in_link;
    logic [W:0]   out_link;
    logic [W-1:0] core_in;
    logic [W-1:0] core_out;

    assign in_link[0] = scan_in;

    generate
        for (genvar i = 0; i < W; i++) begin : g_in_cell
            cw_bound_cell #(.KIND(CELL_INPUT)) u_cell (
                .clk      (clk_a),
                .rst      (ctl.rst),
                .se       (ctl.scan_en),
                .tm       (ctl.test_mode),
                .shift_in (in_link[i]),
                .func_val (func_in[i]),
                .q        (in_link[i+1]),
                .drive    (core_in[i])
            );
        end
    endgenerate

    cw_core #(.W(W)) u_core (
        .clk_a    (clk_a),
        .clk_b    (clk_b),
        .rst      (ctl.rst),
        .se       (ctl.scan_en),
        .scan_in  (in_link[W]),
        .core_in  (core_in),
        .core_out (core_out),
        .scan_out (out_link[0])
    );

    generate
        for (genvar i = 0; i < W; i++) begin : g_out_cell
            cw_bound_cell #(.KIND(CELL_OUTPUT)) u_cell (
                .clk      (clk_b),
                .rst      (ctl.rst),
                .se       (ctl.scan_en),
                .tm       (ctl.test_mode),
                .shift_in (out_link[i]),
                .func_val (core_out[i]),
                .q        (out_link[i+1]),
                .drive    (func_out[i])
            );
        end
    endgenerate

    assign scan_out = out_link[W];

    // R7
    reset_clear_chk: assert property (@(posedge clk_b)
        rst_f |=> (scan_out == 1'b0 && func_out == '0));

endmodule

// File: tb/core_test_wrapper_test.sv
module core_test_wrapper_test;
    localparam int W    = 4;
    localparam int L    = 4 * W;
    localparam int HOLD = 2;

    logic         clk = 1'b0;
    logic         rst_in = 1'b1;
    logic         scan_en_in = 1'b0;
    logic         test_mode_in = 1'b0;
    logic         scan_in = 1'b0;
    logic [W-1:0] func_in = '0;
    logic [W-1:0] func_out;
    logic         scan_out;

    always #2 clk = ~clk;

    core_test_wrapper #(.W(W), .HOLD(HOLD)) uut (
        .clk_a        (clk),
        .clk_b        (clk),
        .rst_in       (rst_in),
        .scan_en_in   (scan_en_in),
        .test_mode_in (test_mode_in),
        .scan_in      (scan_in),
        .func_in      (func_in),
        .func_out     (func_out),
        .scan_out     (scan_out)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit skip   = 1'b1;

    // Model state: chain bits and filter models (0 rst, 1 scan enable, 2 test mode).
    logic [L-1:0] m;
    logic         fo [3];
    int           fc [3];

    initial begin
        m = '0;
        for (int k = 0; k < 3; k++) begin fo[k] = 1'b0; fc[k] = 0; end
    end

    task automatic filt(input int k, input logic din, input logic r);
        if (r) begin
            fo[k] = 1'b0; fc[k] = 0;
        end else if (din == fo[k]) begin
            fc[k] = 0;
        end else if (fc[k] == HOLD - 1) begin
            fo[k] = din; fc[k] = 0;
        end else begin
            fc[k] = fc[k] + 1;
        end
    endtask

    task automatic model_edge();
        logic rf, sf, tf;
        logic [W-1:0] c, a, b, cin;
        rf = fo[0]; sf = fo[1]; tf = fo[2];
        if (rf) begin
            m = '0;
        end else if (sf) begin
            m = {m[L-2:0], scan_in};
        end else begin
            c = m[W-1:0]; a = m[2*W-1:W]; b = m[3*W-1:2*W];
            cin = tf ? c : func_in;
            m = {b, a ^ b, cin ^ {a[W-2:0], a[W-1]}, func_in};
        end
        filt(0, rst_in, 1'b0);
        filt(1, scan_en_in, rf);
        filt(2, test_mode_in, rf);
    endtask

    task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input string req);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        if (!skip) check(req, {scan_out, func_out}, {m[L-1], m[3*W-1:2*W]});
    endtask

    function automatic logic pat(input int p, input int k);
        case (p)
            0:       return (k == 5);
            1:       return k[0];
            default: return ((k * k + k / 3) % 3) == 0;
        endcase
    endfunction

    initial begin
        @(negedge clk);
        repeat (3) tick("R7");
        skip = 1'b0;
        repeat (3) tick("R7");
        rst_in = 1'b0;
        repeat (3) tick("R7");
        // R7: reset state at the ports
        check("R7 reset state", {scan_out, func_out}, '0);

        // R8: capture-mode function, test mode off, all input vectors
        for (int k = 0; k < 40; k++) begin
            func_in = W'((k * 7 + 3) % 16);
            tick("R8 functional");
        end

        // R6: one-cycle pulses on each control are ignored
        scan_en_in = 1'b1; func_in = 4'h9; tick("R6 se pulse");
        scan_en_in = 1'b0; func_in = 4'h6; repeat (4) tick("R6 se pulse");
        test_mode_in = 1'b1; func_in = 4'h3; tick("R6 tm pulse");
        test_mode_in = 1'b0; func_in = 4'hc; repeat (4) tick("R6 tm pulse");
        rst_in = 1'b1; tick("R6 rst pulse");
        rst_in = 1'b0; repeat (4) tick("R6 rst pulse");
        check("R6 pulses ignored", {1'b0, func_out}, {1'b0, m[3*W-1:2*W]});

        // R4/R5: continuity through the whole chain, latch crossing included
        test_mode_in = 1'b1; scan_en_in = 1'b1;
        repeat (3) tick("R6 settle");
        for (int p = 0; p < 3; p++) begin
            for (int k = 0; k < 3 * L; k++) begin
                scan_in = pat(p, k);
                tick("R4 shift");
                if (k >= L - 1) begin
                    checks++;
                    if (scan_out !== pat(p, k + 1 - L)) begin
                        fails++;
                        $display("FAIL R4/R5 continuity: actual=%b expected=%b p=%0d k=%0d",
                                 scan_out, pat(p, k + 1 - L), p, k);
                    end
                end
            end
        end

        // R1/R2/R3: load, capture with test mode on and off, unload
        for (int t = 0; t < 2; t++) begin
            test_mode_in = (t == 0);
            repeat (3) tick("R2 settle");
            for (int v = 0; v < 8; v++) begin
                scan_en_in = 1'b1;
                for (int k = 0; k < L; k++) begin
                    scan_in = pat(2, k + v * 5);
                    tick("R1 load");
                end
                scan_en_in = 1'b0;
                func_in = W'(v * 3 + 1);
                repeat (2) tick("R2 capture");
                scan_en_in = 1'b1;
                for (int k = 0; k < L; k++) begin
                    scan_in = 1'b0;
                    tick("R3 unload");
                end
            end
        end

        // R7: reset while the chain is loaded
        scan_en_in = 1'b1;
        for (int k = 0; k < L; k++) begin scan_in = 1'b1; tick("R7 load"); end
        rst_in = 1'b1;
        repeat (3) tick("R7 reset");
        check("R7 cleared", {scan_out, func_out}, '0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog all: actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule